// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power-management state of a processor core. It moves the core between running, halted, clock-stopped, sleeping and deep-sleeping states, and between three short service phases: cache flush, bus initialisation and system-management handling. It reacts to requests from the core and from the platform. A static strap picks which clock-stopped flavour a stop request selects. The controller does not generate bus cycles, does not flush a cache and does not run a system-management handler. It only asks for them. One-cycle pulses request a halt bus cycle, a stop acknowledge bus cycle, or the start of a flush. A service phase lasts a fixed number of cycles, and each length is a parameter.

The controller remembers whether a clock-stopped state was entered from the halted state. When the stop request is released, it returns there. No new halt bus cycle is requested on that return. The same holds for the return after a flush or after system-management handling.

The state encodings are: Normal = 0, Auto Halt = 1, Stop Grant = 2, Quick Start = 3, Sleep = 4, Deep Sleep = 5, Flush = 6, Bus Init = 7, SMM = 8.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `core_rst_i` is high, the state after each clock edge is Stop Grant (2) if `stop_req_i` is high and `strap_qs_i` is low. Otherwise it is Normal (0). All pulse outputs are low after a reset edge.
- R2: In Normal, a `halt_i` strobe (with no stop request and no SMI) moves the state to Auto Halt (1). `halt_cyc_o` is high for exactly that one cycle.
- R3: A stop request in Normal or Auto Halt moves the state to Stop Grant (2) when `strap_qs_i` = 0, or to Quick Start (3) when `strap_qs_i` = 1. `stop_ack_o` pulses for that one cycle. In Normal the priority is stop request, then SMI, then halt.
- R4: Releasing the stop request in Stop Grant or Quick Start returns the state to Auto Halt if the stopped state was entered from Auto Halt, and to Normal otherwise. `halt_cyc_o` stays low.
- R5: A flush request in Auto Halt or Stop Grant enters Flush (6) with a one-cycle `flush_go_o` pulse. Flush lasts FLUSH_CYCLES cycles, then the state returns to the state it came from with `halt_cyc_o` low.
- R6: A bus-init pulse in Stop Grant (stop request held) enters Bus Init (7) for BINIT_CYCLES cycles. It then returns to Stop Grant if the stop request is still high, or to Normal if it is not. A later release from that Stop Grant goes to Normal.
- R7: In Stop Grant, a sleep request moves the state to Sleep (4). Releasing the sleep request moves it back to Stop Grant.
- R8: An SMI pulse in Normal or Auto Halt enters SMM (8) for SMM_CYCLES cycles. The state then goes to Auto Halt if `smm_ret_halt_i` is high, or to Normal if it is low, with `halt_cyc_o` low.
- R9: In Quick Start, `clk_off_i` high moves the state to Deep Sleep (5). `clk_off_i` low there returns to Quick Start. Quick Start is left only when the stop request is released.
- R10: In Quick Start, flush and bus-init requests are ignored: the state stays Quick Start and `flush_go_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| core_rst_i | input | 1 | Synchronous reset, active high |
| strap_qs_i | input | 1 | Static strap: 1 selects Quick Start, 0 selects Stop Grant |
| halt_i | input | 1 | Halt instruction strobe |
| stop_req_i | input | 1 | Stop-clock request, active high level |
| sleep_req_i | input | 1 | Sleep request level |
| clk_off_i | input | 1 | Input clock is stopped |
| bus_init_i | input | 1 | Bus initialisation pulse |
| flush_req_i | input | 1 | Cache flush request pulse |
| smi_i | input | 1 | System-management interrupt pulse |
| smm_ret_halt_i | input | 1 | SMM exit target: 1 selects Auto Halt, 0 selects Normal |
| state_o | output | 4 | Current state encoding |
| halt_cyc_o | output | 1 | One-cycle request for a halt bus cycle |
| stop_ack_o | output | 1 | One-cycle request for a stop acknowledge bus cycle |
| flush_go_o | output | 1 | One-cycle flush start pulse |

## Verification
The assertions assume that `strap_qs_i` changes only while reset is held. They also assume that the halt, bus-init, flush and SMI inputs are single-cycle strobes, so a request never counts twice. The stimulus changes the strap only inside reset windows and raises each strobe for one cycle. The stimulus keeps `smm_ret_halt_i` steady through each SMM phase, and it drives `clk_off_i` only while the state is Quick Start or Deep Sleep.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
    localparam int ST_W = 4;

    typedef enum logic [ST_W-1:0] {
        ST_NORMAL      = 4'd0,
        ST_AUTO_HALT   = 4'd1,
        ST_STOP_GRANT  = 4'd2,
        ST_QUICK_START = 4'd3,
        ST_SLEEP       = 4'd4,
        ST_DEEP_SLEEP  = 4'd5,
        ST_FLUSH       = 4'd6,
        ST_BUS_INIT    = 4'd7,
        ST_SMM         = 4'd8
    } pwr_state_e;

    typedef struct packed {
        logic halt_cyc;
        logic stop_ack;
        logic flush_go;
    } pwr_pulse_t;
endpackage

// File: rtl/pwr_phase_timer.sv
module pwr_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    // Loaded on entry to a timed phase, then counts down to zero
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_next_state.sv
module pwr_next_state
    import pwr_state_pkg::*;
#(
    parameter int CW            = 3,
    parameter int FLUSH_CYCLES  = 4,
    parameter int BINIT_CYCLES  = 3,
    parameter int SMM_CYCLES    = 5
) (
    input  pwr_state_e    cur_i,
    input  logic          from_halt_i,
    input  pwr_state_e    flush_ret_i,
    input  logic          strap_qs_i,
    input  logic          halt_i,
    input  logic          stop_req_i,
    input  logic          sleep_req_i,
    input  logic          clk_off_i,
    input  logic          bus_init_i,
    input  logic          flush_req_i,
    input  logic          smi_i,
    input  logic          smm_ret_halt_i,
    input  logic          tmr_done_i,
    output pwr_state_e    nxt_o,
    output logic          nxt_from_halt_o,
    output pwr_state_e    nxt_flush_ret_o,
    output pwr_pulse_t    pulse_o,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o
);
    localparam logic [CW-1:0] FLUSH_LD = CW'(FLUSH_CYCLES - 1);
    localparam logic [CW-1:0] BINIT_LD = CW'(BINIT_CYCLES - 1);
    localparam logic [CW-1:0] SMM_LD   = CW'(SMM_CYCLES - 1);

    pwr_state_e stop_tgt;
    pwr_state_e resume_tgt;

    assign stop_tgt   = strap_qs_i  ? ST_QUICK_START : ST_STOP_GRANT;
    assign resume_tgt = from_halt_i ? ST_AUTO_HALT   : ST_NORMAL;

    always_comb begin
        nxt_o           = cur_i;
        nxt_from_halt_o = from_halt_i;
        nxt_flush_ret_o = flush_ret_i;
        pulse_o         = '0;
        tmr_load_o      = 1'b0;
        tmr_val_o       = '0;
        unique case (cur_i)
            ST_NORMAL: begin
                if (stop_req_i) begin
                    nxt_o            = stop_tgt;
                    nxt_from_halt_o  = 1'b0;
                    pulse_o.stop_ack = 1'b1;
                end else if (smi_i) begin
                    nxt_o      = ST_SMM;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SMM_LD;
                end else if (halt_i) begin
                    nxt_o            = ST_AUTO_HALT;
                    pulse_o.halt_cyc = 1'b1;
                end
            end
            ST_AUTO_HALT: begin
                if (stop_req_i) begin
                    nxt_o            = stop_tgt;
                    nxt_from_halt_o  = 1'b1;
                    pulse_o.stop_ack = 1'b1;
                end else if (smi_i) begin
                    nxt_o      = ST_SMM;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SMM_LD;
                end else if (flush_req_i) begin
                    nxt_o            = ST_FLUSH;
                    nxt_flush_ret_o  = ST_AUTO_HALT;
                    pulse_o.flush_go = 1'b1;
                    tmr_load_o       = 1'b1;
                    tmr_val_o        = FLUSH_LD;
                end
            end
            ST_STOP_GRANT: begin
                if (!stop_req_i) begin
                    nxt_o = resume_tgt;
                end else if (bus_init_i) begin
                    nxt_o      = ST_BUS_INIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = BINIT_LD;
                end else if (flush_req_i) begin
                    nxt_o            = ST_FLUSH;
                    nxt_flush_ret_o  = ST_STOP_GRANT;
                    pulse_o.flush_go = 1'b1;
                    tmr_load_o       = 1'b1;
                    tmr_val_o        = FLUSH_LD;
                end else if (sleep_req_i) begin
                    nxt_o = ST_SLEEP;
                end
            end
            ST_QUICK_START: begin
                if (!stop_req_i) begin
                    nxt_o = resume_tgt;
                end else if (clk_off_i) begin
                    nxt_o = ST_DEEP_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (!sleep_req_i) begin
                    nxt_o = ST_STOP_GRANT;
                end
            end
            ST_DEEP_SLEEP: begin
                if (!clk_off_i) begin
                    nxt_o = ST_QUICK_START;
                end
            end
            ST_FLUSH: begin
                if (tmr_done_i) begin
                    nxt_o = flush_ret_i;
                end
            end
            ST_BUS_INIT: begin
                if (tmr_done_i) begin
                    nxt_o           = stop_req_i ? ST_STOP_GRANT : ST_NORMAL;
                    nxt_from_halt_o = 1'b0;
                end
            end
            ST_SMM: begin
                if (tmr_done_i) begin
                    nxt_o = smm_ret_halt_i ? ST_AUTO_HALT : ST_NORMAL;
                end
            end
            default: begin
                nxt_o = ST_NORMAL;
            end
        endcase
    end
endmodule

// File: rtl/pwr_pulse_reg.sv
module pwr_pulse_reg
    import pwr_state_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  pwr_pulse_t pulse_i,
    output logic       halt_cyc_o,
    output logic       stop_ack_o,
    output logic       flush_go_o
);
    pwr_pulse_t pulse_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= pulse_i;
        end
    end

    assign halt_cyc_o = pulse_q.halt_cyc;
    assign stop_ack_o = pulse_q.stop_ack;
    assign flush_go_o = pulse_q.flush_go;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int FLUSH_CYCLES = 4,
    parameter int BINIT_CYCLES = 3,
    parameter int SMM_CYCLES   = 5
) (
    input  logic            clk_i,
    input  logic            core_rst_i,
    input  logic            strap_qs_i,
    input  logic            halt_i,
    input  logic            stop_req_i,
    input  logic            sleep_req_i,
    input  logic            clk_off_i,
    input  logic            bus_init_i,
    input  logic            flush_req_i,
    input  logic            smi_i,
    input  logic            smm_ret_halt_i,
    output logic [ST_W-1:0] state_o,
    output logic            halt_cyc_o,
    output logic            stop_ack_o,
    output logic            flush_go_o
);
    localparam int MAX_A = (FLUSH_CYCLES > BINIT_CYCLES) ? FLUSH_CYCLES : BINIT_CYCLES;
    localparam int MAX_C = (MAX_A > SMM_CYCLES) ? MAX_A : SMM_CYCLES;
    localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    pwr_state_e    cur_q, nxt;
    pwr_state_e    flush_ret_q, nxt_flush_ret;
    logic          from_halt_q, nxt_from_halt;
    pwr_pulse_t    pulse;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;

    pwr_next_state #(
        .CW           (CW),
        .FLUSH_CYCLES (FLUSH_CYCLES),
        .BINIT_CYCLES (BINIT_CYCLES),
        .SMM_CYCLES   (SMM_CYCLES)
    ) u_next (
        .cur_i           (cur_q),
        .from_halt_i     (from_halt_q),
        .flush_ret_i     (flush_ret_q),
        .strap_qs_i      (strap_qs_i),
        .halt_i          (halt_i),
        .stop_req_i      (stop_req_i),
        .sleep_req_i     (sleep_req_i),
        .clk_off_i       (clk_off_i),
        .bus_init_i      (bus_init_i),
        .flush_req_i     (flush_req_i),
        .smi_i           (smi_i),
        .smm_ret_halt_i  (smm_ret_halt_i),
        .tmr_done_i      (tmr_done),
        .nxt_o           (nxt),
        .nxt_from_halt_o (nxt_from_halt),
        .nxt_flush_ret_o (nxt_flush_ret),
        .pulse_o         (pulse),
        .tmr_load_o      (tmr_load),
        .tmr_val_o       (tmr_val)
    );

    pwr_phase_timer #(.CW(CW)) u_timer (
        .clk_i      (clk_i),
        .rst_i      (core_rst_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    // State register: reset lands in Stop Grant while a stop request is held
    // with the Stop Grant strap selected
    always_ff @(posedge clk_i) begin
        if (core_rst_i) begin
            cur_q       <= (stop_req_i && !strap_qs_i) ? ST_STOP_GRANT : ST_NORMAL;
            from_halt_q <= 1'b0;
            flush_ret_q <= ST_NORMAL;
        end else begin
            cur_q       <= nxt;
            from_halt_q <= nxt_from_halt;
            flush_ret_q <= nxt_flush_ret;
        end
    end

    // Output process: registered request pulses
    pwr_pulse_reg u_pulse (
        .clk_i      (clk_i),
        .rst_i      (core_rst_i),
        .pulse_i    (pulse),
        .halt_cyc_o (halt_cyc_o),
        .stop_ack_o (stop_ack_o),
        .flush_go_o (flush_go_o)
    );

    assign state_o = cur_q;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
    import pwr_state_pkg::*;
(
    input logic            clk_i,
    input logic            core_rst_i,
    input logic [ST_W-1:0] state_o,
    input logic            halt_cyc_o,
    input logic            stop_ack_o,
    input logic            flush_go_o
);
    // R1
    reset_land_chk: assert property (@(posedge clk_i)
        core_rst_i |=> (state_o == ST_NORMAL || state_o == ST_STOP_GRANT));

    // R2
    halt_pulse_chk: assert property (@(posedge clk_i) disable iff (core_rst_i)
        halt_cyc_o |-> (state_o == ST_AUTO_HALT && $past(state_o) == ST_NORMAL));

    // R3
    stop_ack_chk: assert property (@(posedge clk_i) disable iff (core_rst_i)
        stop_ack_o |-> ((state_o == ST_STOP_GRANT || state_o == ST_QUICK_START)
                        && ($past(state_o) == ST_NORMAL || $past(state_o) == ST_AUTO_HALT)));

    // R5
    flush_go_chk: assert property (@(posedge clk_i) disable iff (core_rst_i)
        flush_go_o |-> (state_o == ST_FLUSH && $past(state_o) != ST_FLUSH));

    // R9
    deep_entry_chk: assert property (@(posedge clk_i) disable iff (core_rst_i)
        (state_o == ST_DEEP_SLEEP) |->
            ($past(state_o) == ST_QUICK_START || $past(state_o) == ST_DEEP_SLEEP));

    // R10
    qs_exit_chk: assert property (@(posedge clk_i) disable iff (core_rst_i)
        ($past(state_o) == ST_QUICK_START && state_o != ST_QUICK_START) |->
            (state_o == ST_DEEP_SLEEP || state_o == ST_NORMAL || state_o == ST_AUTO_HALT));

    // R2 R3 R5
    pulse_excl_chk: assert property (@(posedge clk_i) disable iff (core_rst_i)
        $onehot0({halt_cyc_o, stop_ack_o, flush_go_o}));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
    .clk_i      (clk_i),
    .core_rst_i (core_rst_i),
    .state_o    (state_o),
    .halt_cyc_o (halt_cyc_o),
    .stop_ack_o (stop_ack_o),
    .flush_go_o (flush_go_o)
);

// File: tb/pwr_state_ctrl_bench.sv
`timescale 1ns/100ps
module pwr_state_ctrl_bench;
    localparam logic [3:0] NRM = 4'd0, AH = 4'd1, SG = 4'd2, QS = 4'd3,
                           SL = 4'd4, DS = 4'd5, FL = 4'd6, BI = 4'd7, SM = 4'd8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic core_rst, strap_qs, halt, stop_req, sleep_req, clk_off;
    logic bus_init, flush_req, smi, smm_ret_halt;
    logic [3:0] state;
    logic halt_cyc, stop_ack, flush_go;

    // pending stimulus, applied at the next falling edge
    logic n_rst = 1'b1, n_strap = 1'b0, n_halt = 1'b0, n_stop = 1'b0, n_sleep = 1'b0;
    logic n_clkoff = 1'b0, n_binit = 1'b0, n_flush = 1'b0, n_smi = 1'b0, n_ret = 1'b0;

    typedef struct {
        logic [3:0] st;
        logic       h;
        logic       a;
        logic       f;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;

    pwr_state_ctrl u_pwr_state_ctrl (
        .clk_i          (clk),
        .core_rst_i     (core_rst),
        .strap_qs_i     (strap_qs),
        .halt_i         (halt),
        .stop_req_i     (stop_req),
        .sleep_req_i    (sleep_req),
        .clk_off_i      (clk_off),
        .bus_init_i     (bus_init),
        .flush_req_i    (flush_req),
        .smi_i          (smi),
        .smm_ret_halt_i (smm_ret_halt),
        .state_o        (state),
        .halt_cyc_o     (halt_cyc),
        .stop_ack_o     (stop_ack),
        .flush_go_o     (flush_go)
    );

    initial begin
        core_rst = 1'b1; strap_qs = 1'b0; halt = 1'b0; stop_req = 1'b0; sleep_req = 1'b0;
        clk_off = 1'b0; bus_init = 1'b0; flush_req = 1'b0; smi = 1'b0; smm_ret_halt = 1'b0;
    end

    // Driver: apply pending inputs, push what the next edge must produce
    task automatic cyc(input logic [3:0] st, input logic h, input logic a,
                       input logic f, input string tag);
        exp_t e;
        @(negedge clk);
        core_rst = n_rst; strap_qs = n_strap; halt = n_halt; stop_req = n_stop;
        sleep_req = n_sleep; clk_off = n_clkoff; bus_init = n_binit;
        flush_req = n_flush; smi = n_smi; smm_ret_halt = n_ret;
        e.st = st; e.h = h; e.a = a; e.f = f; e.tag = tag;
        exp_q.push_back(e);
        n_halt = 1'b0; n_binit = 1'b0; n_flush = 1'b0; n_smi = 1'b0;
    endtask

    task automatic hold(input int n, input logic [3:0] st, input string tag);
        for (int i = 0; i < n; i++) cyc(st, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (state !== e.st || halt_cyc !== e.h || stop_ack !== e.a || flush_go !== e.f) begin
                n_err++;
                $display("FAIL %s: state=%0d h=%b a=%b f=%b expected state=%0d h=%b a=%b f=%b",
                         e.tag, state, halt_cyc, stop_ack, flush_go, e.st, e.h, e.a, e.f);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset to Normal, then to Stop Grant with stop held and strap low
        cyc(NRM, 0, 0, 0, "R1 reset idle");
        n_stop = 1;
        cyc(SG, 0, 0, 0, "R1 reset with stop held");
        // R4: release from Stop Grant entered by reset goes to Normal
        n_rst = 0; n_stop = 0;
        cyc(NRM, 0, 0, 0, "R4 release to Normal");
        // R2: halt
        n_halt = 1;
        cyc(AH, 1, 0, 0, "R2 halt entry");
        cyc(AH, 0, 0, 0, "R2 pulse one cycle");
        // R3: stop from Auto Halt
        n_stop = 1;
        cyc(SG, 0, 1, 0, "R3 stop from halt");
        cyc(SG, 0, 0, 0, "R3 ack one cycle");
        // R5: flush in Stop Grant
        n_flush = 1;
        cyc(FL, 0, 0, 1, "R5 flush entry from SG");
        hold(3, FL, "R5 flush busy");
        cyc(SG, 0, 0, 0, "R5 flush back to SG");
        // R7: sleep
        n_sleep = 1;
        cyc(SL, 0, 0, 0, "R7 sleep entry");
        cyc(SL, 0, 0, 0, "R7 sleep hold");
        n_sleep = 0;
        cyc(SG, 0, 0, 0, "R7 sleep exit");
        // R6: bus init with stop held
        n_binit = 1;
        cyc(BI, 0, 0, 0, "R6 bus init entry");
        hold(2, BI, "R6 bus init busy");
        cyc(SG, 0, 0, 0, "R6 back to SG");
        n_stop = 0;
        cyc(NRM, 0, 0, 0, "R6 origin cleared");
        // R4: return to Auto Halt with no halt cycle
        n_halt = 1;
        cyc(AH, 1, 0, 0, "R2 halt again");
        n_stop = 1;
        cyc(SG, 0, 1, 0, "R3 stop from halt");
        n_stop = 0;
        cyc(AH, 0, 0, 0, "R4 release to Auto Halt");
        // R5: flush in Auto Halt
        n_flush = 1;
        cyc(FL, 0, 0, 1, "R5 flush entry from AH");
        hold(3, FL, "R5 flush busy");
        cyc(AH, 0, 0, 0, "R5 flush back to AH");
        // R8: SMI with both exit targets
        n_ret = 1; n_smi = 1;
        cyc(SM, 0, 0, 0, "R8 smm entry");
        hold(4, SM, "R8 smm busy");
        cyc(AH, 0, 0, 0, "R8 smm exit to AH");
        n_ret = 0; n_smi = 1;
        cyc(SM, 0, 0, 0, "R8 smm entry");
        hold(4, SM, "R8 smm busy");
        cyc(NRM, 0, 0, 0, "R8 smm exit to Normal");
        // R1: Quick Start strap, reset with stop held lands in Normal
        n_rst = 1; n_strap = 1; n_stop = 1;
        cyc(NRM, 0, 0, 0, "R1 reset with QS strap");
        n_rst = 0;
        cyc(QS, 0, 1, 0, "R3 stop to Quick Start");
        // R10
        n_flush = 1; n_binit = 1;
        cyc(QS, 0, 0, 0, "R10 flush and bus init ignored");
        cyc(QS, 0, 0, 0, "R10 still Quick Start");
        // R9
        n_clkoff = 1;
        cyc(DS, 0, 0, 0, "R9 deep sleep entry");
        cyc(DS, 0, 0, 0, "R9 deep sleep hold");
        n_clkoff = 0;
        cyc(QS, 0, 0, 0, "R9 deep sleep exit");
        n_stop = 0;
        cyc(NRM, 0, 0, 0, "R9 Quick Start exit");
        // R4 via Quick Start from Auto Halt
        n_halt = 1;
        cyc(AH, 1, 0, 0, "R2 halt");
        n_stop = 1;
        cyc(QS, 0, 1, 0, "R3 stop from halt to QS");
        n_stop = 0;
        cyc(AH, 0, 0, 0, "R4 QS release to Auto Halt");
        // R6: bus init ending with stop released
        n_rst = 1; n_strap = 0; n_stop = 1;
        cyc(SG, 0, 0, 0, "R1 reset into SG");
        n_rst = 0; n_binit = 1;
        cyc(BI, 0, 0, 0, "R6 bus init entry");
        n_stop = 0;
        hold(2, BI, "R6 bus init busy");
        cyc(NRM, 0, 0, 0, "R6 bus init exit to Normal");
        // drain
        repeat (3) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule